// File: doc/BRIEF.md
# Configuration Upload Sequencer

This block loads a static configuration image into a switch device attached over SPI and checks that the load worked. It never touches the serial lines. Every access goes out as a register transaction on a generic command port that carries address, write flag, write data and byte length, and answers with done, error and read data. A burst master sits behind that port and moves the image bytes.

One run goes like this. Transmit is stopped on every port with a read-modify-write of the port control word. The sequencer waits long enough for a frame already in flight to leave the wire. It then issues a cold reset, waits for the device to recover, writes the image, and reads back one status word. A bad status or a failed bus transaction sends the sequencer back to the reset step, up to a fixed number of attempts.

Time is measured with a free-running one-microsecond tick.

Top module: `cfg_upload_seq`

## Requirements
- R1: A pulse on `start_i` is taken only while `busy_o` is low. `busy_o` stays high from the cycle after an accepted start through the single cycle in which `done_o` is high, and falls on the next cycle. A start seen while busy changes nothing. No command is presented while idle.
- R2: A run begins with two commands:
  - a 4-byte read at `PORT_ADDR`;
  - a 4-byte write to the same address, whose data is the read data ORed with `port_mask_i`, zero-extended.
- R3: If either inhibit command ends with `cmd_err_i`, the run ends at once with `err_code_o` = 1. No reset command is issued and `fail_cnt_o` = 0.
- R4: After the inhibit write completes, the reset command is held back until `DRAIN_US`+1 ticks have been seen. This gives at least `DRAIN_US` microseconds of drain time.
- R5: The cold reset is a 4-byte write to `RST_ADDR`. Its data has exactly one bit set: bit 3 when `variant_i` = 0, bit 2 when `variant_i` = 1.
- R6: After the reset write completes, the sequencer waits `RESET_US`+1 ticks. It then issues a write at `CFG_ADDR` whose length is `img_len_i`.
- R7: The image write is followed by a 4-byte read at `STAT_ADDR`. The status word decodes as follows:
  - bit 31: configuration valid;
  - bit 30: local CRC error;
  - bit 29: ID mismatch;
  - bit 28: global CRC error.

  The attempt passes only when bit 31 is 1 and bits 30, 29 and 28 are all 0. Bits 27..0 are ignored.
- R8: An attempt fails on a status that does not pass, or on `cmd_err_i` during the reset, image or status command. A failed attempt goes straight back to the reset command, without repeating the inhibit step or the drain wait.
- R9: After `MAX_TRY` (10) failed attempts, the run ends with `err_code_o` = 2 and `fail_cnt_o` = 10.
- R10: On success the run ends with `err_code_o` = 0, and `fail_cnt_o` gives the number of failed attempts before the passing one. Both outputs hold until the next accepted start.
- R11: A command's valid, write flag, address, data and length stay stable from the cycle it is presented until `cmd_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run (taken only when idle) |
| variant_i | input | 1 | Selects the reset bit: 0 selects bit 3, 1 selects bit 2 |
| port_mask_i | input | NPORT | Ports whose transmit is inhibited |
| img_len_i | input | LW | Image length in bytes |
| us_tick_i | input | 1 | One-cycle pulse once per microsecond |
| cmd_valid_o | output | 1 | Command presented |
| cmd_write_o | output | 1 | 1 for write, 0 for read |
| cmd_addr_o | output | AW | Word address |
| cmd_wdata_o | output | 32 | Write data for register writes |
| cmd_len_o | output | LW | Transfer length in bytes |
| cmd_done_i | input | 1 | Command complete (one cycle) |
| cmd_err_i | input | 1 | Command failed; valid with done |
| cmd_rdata_i | input | 32 | Read data; valid with done |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished (one cycle) |
| err_code_o | output | 2 | 0 ok, 1 inhibit failed, 2 I/O failure after retries |
| fail_cnt_o | output | 4 | Failed attempts in the last run |

## Verification
The hardest states to reach are the retry boundaries: a pass on the tenth attempt, and giving up after exactly ten failures. Reaching them needs the device side to fail in a chosen way at a chosen command position, again and again.

The bench scripts every response in order in a queue. Each entry fixes the error flag and read data for one command. This lets it mix status failures with bus errors injected into the reset, image and status commands. The waits are shortened by parameters so that every retry path fits in a short run. The delay checks then measure tick counts between a command's completion and the next command's issue.

// File: rtl/cfg_upload_pkg.sv
package cfg_upload_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_INH_RD, ST_INH_WR, ST_DRAIN, ST_RST_WR,
    ST_RST_WAIT, ST_IMG_WR, ST_STAT_RD, ST_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_INHIBIT = 2'd1,
    RES_IO      = 2'd2
  } seq_result_e;

  typedef struct packed {
    logic cfg_ok;
    logic crc_local;
    logic id_bad;
    logic crc_global;
  } stat_flags_t;
endpackage

// File: rtl/cus_wait_timer.sv
module cus_wait_timer #(
  parameter int unsigned TW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [TW-1:0] limit_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  // limit_i + 1 ticks: the first tick may arrive right after entry
  assign expire_o = run_i && tick_i && (cnt_q == limit_i);
endmodule

// File: rtl/cus_status_chk.sv
module cus_status_chk
  import cfg_upload_pkg::*;
#(
  parameter int unsigned OK_BIT   = 31,
  parameter int unsigned LCRC_BIT = 30,
  parameter int unsigned ID_BIT   = 29,
  parameter int unsigned GCRC_BIT = 28
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              pass_o
);
  stat_flags_t flags;

  always_comb begin
    flags.cfg_ok     = word_i[OK_BIT];
    flags.crc_local  = word_i[LCRC_BIT];
    flags.id_bad     = word_i[ID_BIT];
    flags.crc_global = word_i[GCRC_BIT];
    pass_o = flags.cfg_ok && !flags.crc_local && !flags.id_bad && !flags.crc_global;
  end
endmodule

// File: rtl/cus_attempt_ctr.sv
module cus_attempt_ctr #(
  parameter int unsigned MAX_TRY = 10,
  localparam int unsigned FW = $clog2(MAX_TRY + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          bump_i,
  output logic [FW-1:0] count_o,
  output logic          last_o
);
  logic [FW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt_q <= '0;
    else if (clear_i)                          cnt_q <= '0;
    else if (bump_i && cnt_q != FW'(MAX_TRY))  cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
  assign last_o  = (cnt_q == FW'(MAX_TRY - 1));
endmodule

// File: rtl/cfg_upload_seq.sv
module cfg_upload_seq
  import cfg_upload_pkg::*;
#(
  parameter int unsigned   AW          = 21,
  parameter int unsigned   LW          = 16,
  parameter int unsigned   NPORT       = 5,
  parameter int unsigned   DRAIN_US    = 500,
  parameter int unsigned   RESET_US    = 1000,
  parameter int unsigned   MAX_TRY     = 10,
  parameter int unsigned   RST_BIT_STD = 3,
  parameter int unsigned   RST_BIT_ALT = 2,
  parameter logic [AW-1:0] PORT_ADDR   = 'h11,
  parameter logic [AW-1:0] RST_ADDR    = 'h100440,
  parameter logic [AW-1:0] CFG_ADDR    = 'h20000,
  parameter logic [AW-1:0] STAT_ADDR   = 'h1,
  localparam int unsigned  TW = $clog2(((DRAIN_US > RESET_US) ? DRAIN_US : RESET_US) + 1),
  localparam int unsigned  FW = $clog2(MAX_TRY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              variant_i,
  input  logic [NPORT-1:0]  port_mask_i,
  input  logic [LW-1:0]     img_len_i,
  input  logic              us_tick_i,
  output logic              cmd_valid_o,
  output logic              cmd_write_o,
  output logic [AW-1:0]     cmd_addr_o,
  output logic [WORD_W-1:0] cmd_wdata_o,
  output logic [LW-1:0]     cmd_len_o,
  input  logic              cmd_done_i,
  input  logic              cmd_err_i,
  input  logic [WORD_W-1:0] cmd_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_code_o,
  output logic [FW-1:0]     fail_cnt_o
);
  seq_state_e        st_q, st_d;
  seq_result_e       res_q;
  logic [NPORT-1:0]  mask_q;
  logic              variant_q;
  logic [LW-1:0]     img_len_q;
  logic [WORD_W-1:0] inh_word_q;
  logic [WORD_W-1:0] rst_word;

  logic accept, wait_run, wait_done, stat_pass, try_fail, try_last, inh_fail;
  logic [TW-1:0] wait_limit;

  assign accept    = (st_q == ST_IDLE) && start_i;
  assign wait_run  = (st_q == ST_DRAIN) || (st_q == ST_RST_WAIT);
  assign wait_limit = (st_q == ST_DRAIN) ? TW'(DRAIN_US) : TW'(RESET_US);
  assign inh_fail  = cmd_done_i && cmd_err_i && ((st_q == ST_INH_RD) || (st_q == ST_INH_WR));
  assign try_fail  = cmd_done_i &&
                     ((cmd_err_i && (st_q inside {ST_RST_WR, ST_IMG_WR, ST_STAT_RD})) ||
                      ((st_q == ST_STAT_RD) && !stat_pass));
  assign rst_word  = WORD_W'(1) << (variant_q ? RST_BIT_ALT : RST_BIT_STD);

  cus_wait_timer #(.TW(TW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (wait_run),
    .tick_i  (us_tick_i),
    .limit_i (wait_limit),
    .expire_o(wait_done)
  );

  cus_status_chk u_stat (
    .word_i(cmd_rdata_i),
    .pass_o(stat_pass)
  );

  cus_attempt_ctr #(.MAX_TRY(MAX_TRY)) u_tries (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(accept),
    .bump_i (try_fail),
    .count_o(fail_cnt_o),
    .last_o (try_last)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:     if (start_i) st_d = ST_INH_RD;
      ST_INH_RD:   if (cmd_done_i) st_d = cmd_err_i ? ST_FIN : ST_INH_WR;
      ST_INH_WR:   if (cmd_done_i) st_d = cmd_err_i ? ST_FIN : ST_DRAIN;
      ST_DRAIN:    if (wait_done) st_d = ST_RST_WR;
      ST_RST_WR:   if (cmd_done_i && !cmd_err_i) st_d = ST_RST_WAIT;
      ST_RST_WAIT: if (wait_done) st_d = ST_IMG_WR;
      ST_IMG_WR:   if (cmd_done_i && !cmd_err_i) st_d = ST_STAT_RD;
      ST_STAT_RD:  if (cmd_done_i && !cmd_err_i && stat_pass) st_d = ST_FIN;
      ST_FIN:      st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
    if (try_fail) st_d = try_last ? ST_FIN : ST_RST_WR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      res_q      <= RES_OK;
      mask_q     <= '0;
      variant_q  <= 1'b0;
      img_len_q  <= '0;
      inh_word_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        res_q     <= RES_OK;
        mask_q    <= port_mask_i;
        variant_q <= variant_i;
        img_len_q <= img_len_i;
      end
      if ((st_q == ST_INH_RD) && cmd_done_i && !cmd_err_i)
        inh_word_q <= cmd_rdata_i | WORD_W'(mask_q);
      if (inh_fail)             res_q <= RES_INHIBIT;
      if (try_fail && try_last) res_q <= RES_IO;
    end
  end

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_write_o = 1'b0;
    cmd_addr_o  = '0;
    cmd_wdata_o = '0;
    cmd_len_o   = LW'(WORD_BYTES);
    case (st_q)
      ST_INH_RD: begin
        cmd_valid_o = 1'b1;
        cmd_addr_o  = PORT_ADDR;
      end
      ST_INH_WR: begin
        cmd_valid_o = 1'b1;
        cmd_write_o = 1'b1;
        cmd_addr_o  = PORT_ADDR;
        cmd_wdata_o = inh_word_q;
      end
      ST_RST_WR: begin
        cmd_valid_o = 1'b1;
        cmd_write_o = 1'b1;
        cmd_addr_o  = RST_ADDR;
        cmd_wdata_o = rst_word;
      end
      ST_IMG_WR: begin
        cmd_valid_o = 1'b1;
        cmd_write_o = 1'b1;
        cmd_addr_o  = CFG_ADDR;
        cmd_len_o   = img_len_q;
      end
      ST_STAT_RD: begin
        cmd_valid_o = 1'b1;
        cmd_addr_o  = STAT_ADDR;
      end
      default: ;
    endcase
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_FIN);
  assign err_code_o = res_q;
endmodule

module cfg_upload_seq_chk #(
  parameter int unsigned   AW          = 21,
  parameter int unsigned   LW          = 16,
  parameter int unsigned   NPORT       = 5,
  parameter int unsigned   MAX_TRY     = 10,
  parameter int unsigned   FW          = 4,
  parameter int unsigned   RST_BIT_STD = 3,
  parameter int unsigned   RST_BIT_ALT = 2,
  parameter logic [AW-1:0] PORT_ADDR   = 'h11,
  parameter logic [AW-1:0] RST_ADDR    = 'h100440
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic             cmd_valid_o,
  input logic             cmd_write_o,
  input logic [AW-1:0]    cmd_addr_o,
  input logic [31:0]      cmd_wdata_o,
  input logic [LW-1:0]    cmd_len_o,
  input logic             cmd_done_i,
  input logic [1:0]       err_code_o,
  input logic [FW-1:0]    fail_cnt_o,
  input logic [NPORT-1:0] mask_q
);
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);  // R1
  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o);  // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o);  // R1
  AST_INH_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_write_o && cmd_addr_o == PORT_ADDR
      |-> (cmd_wdata_o[NPORT-1:0] & mask_q) == mask_q);  // R2
  AST_INH_NO_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_code_o == 2'd1 |-> fail_cnt_o == '0);  // R3
  AST_RST_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_addr_o == RST_ADDR
      |-> $countones(cmd_wdata_o) == 1 && (cmd_wdata_o[RST_BIT_STD] || cmd_wdata_o[RST_BIT_ALT]));  // R5
  AST_FAIL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_cnt_o <= FW'(MAX_TRY));  // R9
  AST_IO_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_code_o == 2'd2 |-> fail_cnt_o == FW'(MAX_TRY));  // R9
  AST_CMD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_write_o) && $stable(cmd_addr_o)
      && $stable(cmd_wdata_o) && $stable(cmd_len_o));  // R11
endmodule

bind cfg_upload_seq cfg_upload_seq_chk #(
  .AW(AW), .LW(LW), .NPORT(NPORT), .MAX_TRY(MAX_TRY), .FW(FW),
  .RST_BIT_STD(RST_BIT_STD), .RST_BIT_ALT(RST_BIT_ALT),
  .PORT_ADDR(PORT_ADDR), .RST_ADDR(RST_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .cmd_valid_o(cmd_valid_o), .cmd_write_o(cmd_write_o), .cmd_addr_o(cmd_addr_o),
  .cmd_wdata_o(cmd_wdata_o), .cmd_len_o(cmd_len_o), .cmd_done_i(cmd_done_i),
  .err_code_o(err_code_o), .fail_cnt_o(fail_cnt_o), .mask_q(mask_q)
);

// File: tb/cfg_upload_seq_bench.sv
`timescale 1ns/1ps
module cfg_upload_seq_bench;
  localparam int DRAIN = 4;
  localparam int RWAIT = 6;
  localparam logic [20:0] PORT_A = 'h11;
  localparam logic [20:0] RST_A  = 'h100440;
  localparam logic [20:0] CFG_A  = 'h20000;
  localparam logic [20:0] STAT_A = 'h1;
  localparam logic [15:0] IMG_LEN = 16'd256;

  typedef struct packed { logic w; logic [20:0] a; logic [31:0] d; logic [15:0] l; } cmd_t;
  typedef struct packed { logic err; logic [31:0] data; } resp_t;

  logic clk = 0, rst_n = 0;
  logic start = 0, variant = 0, us_tick = 0;
  logic [4:0] mask_in = '0;
  logic cmd_done = 0, cmd_err = 0;
  logic [31:0] cmd_rdata = '0;
  logic cmd_valid_o, cmd_write_o, busy_o, done_o;
  logic [20:0] cmd_addr_o;
  logic [31:0] cmd_wdata_o;
  logic [15:0] cmd_len_o;
  logic [1:0] err_code_o;
  logic [3:0] fail_cnt_o;

  int n_chk = 0, n_fail = 0;
  int tick_cnt = 0, last_done_tick = 0, div = 0, lat = 0;
  bit pend = 0, in_run = 0;
  cmd_t cur = '0, prev = '0;
  cmd_t obs_q[$], exp_q[$];
  resp_t resp_q[$];

  always #2.5 clk = ~clk;

  cfg_upload_seq #(.DRAIN_US(DRAIN), .RESET_US(RWAIT)) u_cfg_upload_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .variant_i(variant),
    .port_mask_i(mask_in), .img_len_i(IMG_LEN), .us_tick_i(us_tick),
    .cmd_valid_o(cmd_valid_o), .cmd_write_o(cmd_write_o), .cmd_addr_o(cmd_addr_o),
    .cmd_wdata_o(cmd_wdata_o), .cmd_len_o(cmd_len_o), .cmd_done_i(cmd_done),
    .cmd_err_i(cmd_err), .cmd_rdata_i(cmd_rdata), .busy_o(busy_o), .done_o(done_o),
    .err_code_o(err_code_o), .fail_cnt_o(fail_cnt_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [20:0] a);
    if (a == PORT_A) return "R2";
    if (a == RST_A)  return "R5";
    if (a == CFG_A)  return "R6";
    return "R7";
  endfunction

  // microsecond tick: one pulse every third cycle
  always @(negedge clk) begin
    div = (div == 2) ? 0 : div + 1;
    us_tick = (div == 0);
  end
  always @(posedge clk) if (us_tick) tick_cnt++;

  // device-side responder, scripted by resp_q
  always @(negedge clk) begin
    if (cmd_done) begin
      cmd_done = 0;
      cmd_err  = 0;
    end else if (cmd_valid_o) begin
      if (!pend) begin
        pend = 1;
        lat  = 2;
        cur  = '{cmd_write_o, cmd_addr_o, cmd_wdata_o, cmd_len_o};
        obs_q.push_back(cur);
        if (cur.a == RST_A && prev.a == PORT_A)
          chk(tick_cnt - last_done_tick inside {[DRAIN+1:DRAIN+2]}, "R4", "drain ticks",
              tick_cnt - last_done_tick, DRAIN + 1);
        else if (cur.a == RST_A)
          chk(tick_cnt - last_done_tick < DRAIN, "R8", "retry skips drain",
              tick_cnt - last_done_tick, 0);
        if (cur.a == CFG_A)
          chk(tick_cnt - last_done_tick inside {[RWAIT+1:RWAIT+2]}, "R6", "reset wait ticks",
              tick_cnt - last_done_tick, RWAIT + 1);
      end else begin
        chk({cmd_write_o, cmd_addr_o, cmd_wdata_o, cmd_len_o} == cur, "R11", "cmd held addr",
            cmd_addr_o, cur.a);
        if (lat != 0) lat--;
        else begin
          resp_t r;
          r = (resp_q.size() != 0) ? resp_q.pop_front() : '0;
          cmd_done = 1;
          cmd_err  = r.err;
          cmd_rdata = r.data;
          pend = 0;
          prev = cur;
          last_done_tick = tick_cnt;
        end
      end
    end
  end

  // per-cycle model: busy throughout a run
  always @(negedge clk) if (in_run) chk(busy_o, "R1", "busy during run", busy_o, 1);

  task automatic e(input bit w, input logic [20:0] a, input logic [31:0] d,
                   input logic [15:0] l, input bit err, input logic [31:0] data);
    exp_q.push_back('{w, a, d, l});
    resp_q.push_back('{err, data});
  endtask

  task automatic inhibit(input logic [31:0] rd, input logic [4:0] m);
    e(0, PORT_A, 0, 4, 0, rd);
    e(1, PORT_A, rd | {27'd0, m}, 4, 0, 0);
  endtask

  task automatic attempt(input bit v, input bit rst_err, input bit img_err,
                         input bit st_err, input logic [31:0] st);
    e(1, RST_A, v ? 32'h4 : 32'h8, 4, rst_err, 0);
    if (rst_err) return;
    e(1, CFG_A, 0, IMG_LEN, img_err, 0);
    if (img_err) return;
    e(0, STAT_A, 0, 4, st_err, st);
  endtask

  task automatic run(input bit v, input logic [4:0] m, input logic [1:0] ecode,
                     input int efail, input string req, input bit poke);
    int cyc;
    obs_q.delete();
    variant = v;
    mask_in = m;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; in_run = 1;
    cyc = 0;
    while (!done_o && cyc < 50000) begin
      @(negedge clk);
      cyc++;
      start = poke && (cyc == 5 || cyc == 40);
      if (poke && cyc == 6) mask_in = '0;
    end
    start = 0;
    in_run = 0;
    chk(done_o, req, "done seen", done_o, 1);
    chk(err_code_o == ecode, req, "err_code", err_code_o, ecode);
    chk(fail_cnt_o == efail, req, "fail_cnt", fail_cnt_o, efail);
    @(negedge clk);
    chk(!busy_o && !done_o, "R1", "idle after done", busy_o, 0);
    chk(err_code_o == ecode, "R10", "err_code held", err_code_o, ecode);
    chk(obs_q.size() == exp_q.size(), req, "command count", obs_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++) begin
      chk(obs_q[i].a == exp_q[i].a && obs_q[i].w == exp_q[i].w && obs_q[i].l == exp_q[i].l,
          tag_of(exp_q[i].a), "cmd addr", obs_q[i].a, exp_q[i].a);
      chk(obs_q[i].d == exp_q[i].d, tag_of(exp_q[i].a), "cmd data", obs_q[i].d, exp_q[i].d);
    end
    chk(resp_q.size() == 0, req, "responses consumed", resp_q.size(), 0);
    exp_q.delete();
    resp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o && !done_o && !cmd_valid_o, "R1", "reset idle", busy_o, 0);
    chk(err_code_o == 0 && fail_cnt_o == 0, "R10", "reset result", err_code_o, 0);

    // R2 R5 R6 R7 R10: pass at first try, variant 0; late starts and mask change ignored (R1)
    inhibit(32'hA0, 5'h1F);
    attempt(0, 0, 0, 0, 32'h8000_0000);
    run(0, 5'h1F, 2'd0, 0, "R10", 1);

    // R7 R8: each status flag fails once, then pass with don't-care low bits; variant 1
    inhibit(32'h100, 5'h03);
    attempt(1, 0, 0, 0, 32'hA000_0000);
    attempt(1, 0, 0, 0, 32'hC000_0000);
    attempt(1, 0, 0, 0, 32'h9000_0000);
    attempt(1, 0, 0, 0, 32'h0000_0000);
    attempt(1, 0, 0, 0, 32'h8FFF_FFFF);
    run(1, 5'h03, 2'd0, 4, "R7", 0);

    // R8: bus errors on reset, image and status commands
    inhibit(32'h0, 5'h10);
    attempt(0, 1, 0, 0, 0);
    attempt(0, 0, 1, 0, 0);
    attempt(0, 0, 0, 1, 32'h8000_0000);
    attempt(0, 0, 0, 0, 32'h8000_0000);
    run(0, 5'h10, 2'd0, 3, "R8", 0);

    // R9: pass on the last permitted attempt
    inhibit(32'h0, 5'h01);
    for (int i = 0; i < 9; i++) attempt(0, 0, 0, 0, 32'h4000_0000);
    attempt(0, 0, 0, 0, 32'h8000_0000);
    run(0, 5'h01, 2'd0, 9, "R9", 0);

    // R9: ten failures exhaust the retries
    inhibit(32'h0, 5'h1F);
    for (int i = 0; i < 10; i++) attempt(1, 0, 0, 0, 32'h0);
    run(1, 5'h1F, 2'd2, 10, "R9", 0);

    // R3: inhibit read error, then inhibit write error
    e(0, PORT_A, 0, 4, 1, 0);
    run(0, 5'h1F, 2'd1, 0, "R3", 0);
    e(0, PORT_A, 0, 4, 0, 32'h5);
    e(1, PORT_A, 32'h5 | 32'h1F, 4, 1, 0);
    run(0, 5'h1F, 2'd1, 0, "R3", 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule